// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for a single-register load or store in a 32-bit load/store processor. It also forms the value that the base register would hold after the access. The operand offset comes from one of two sources. The first is an unsigned immediate. The second is a register value scaled by a left shift, so an element index can be turned into a byte offset. The offset is added to the base or subtracted from it.

Two indexing styles are supported:

- **Pre-indexed:** the access uses the adjusted address. The base either keeps its value or takes the adjusted address, as the writeback request selects.
- **Post-indexed:** the access uses the untouched base, and the adjusted address is always written back.

A flag reports when the access address does not suit the requested access width. The flag is informational only and does not block writeback. Register-file access, instruction decode and memory timing belong to the surrounding pipeline.

By default a register stage sits on the outputs, so results appear one clock after the operands. A parameter removes that stage and makes the block purely combinational.

Top module: `ls_agu_top`

## Requirements
- R1: With `ofs_sel_i`=0 the offset is `imm_i` zero-extended to 32 bits. With `ofs_sel_i`=1 the offset is `rofs_i` shifted left by `shamt_i`, and bits moved past bit 31 are dropped. For example, an index of 3 shifted by 2 gives 12.
- R2: With `sub_i`=0 the adjusted address is base plus offset, and with `sub_i`=1 it is base minus offset. Both wrap modulo 2^32. For example, 0x200 minus 4 gives 0x1FC.
- R3: Pre-indexed access without writeback (`post_i`=0, `wb_i`=0) gives `addr_o` = adjusted address, `new_base_o` = unchanged base, and `wb_en_o`=0.
- R4: Pre-indexed access with writeback (`post_i`=0, `wb_i`=1) gives `addr_o` = `new_base_o` = adjusted address, and `wb_en_o`=1.
- R5: Post-indexed access (`post_i`=1) gives `addr_o` = original base, `new_base_o` = adjusted address, and `wb_en_o`=1, whatever the value of `wb_i`. For example, base 0x200 with immediate 12 accesses 0x200 and leaves 0x20C.
- R6: `misalign_o` is judged on `addr_o`, using the `size_i` encoding below. It has no effect on `wb_en_o` or `new_base_o`.
  - 00 is a byte access and never flags.
  - 01 is a halfword access and flags when bit 0 of the address is set.
  - 10 is a word access and flags when either of bits 1:0 is set.
  - 11 is treated as a word access.
- R7: With `REG_OUT`=1, each output reflects the operands present at the previous rising clock edge and holds steady between edges. While `rst` is high, all outputs are zero one edge later.
- R8: Every shift amount from 0 to 31 is honoured. Shifting by 31 leaves only bit 0 of `rofs_i` in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 32 | Base register value |
| ofs_sel_i | input | 1 | 0 selects the immediate offset, 1 selects the scaled register offset |
| imm_i | input | 12 | Unsigned immediate offset |
| rofs_i | input | 32 | Register offset value |
| shamt_i | input | 5 | Left-shift amount applied to the register offset |
| sub_i | input | 1 | 1 subtracts the offset, 0 adds it |
| post_i | input | 1 | 1 selects post-indexed, 0 selects pre-indexed |
| wb_i | input | 1 | Writeback request for pre-indexed access |
| size_i | input | 2 | Access width: 00 byte, 01 halfword, 10 or 11 word |
| addr_o | output | 32 | Effective access address |
| new_base_o | output | 32 | Value for the base register after the access |
| wb_en_o | output | 1 | Base register writeback strobe |
| misalign_o | output | 1 | Access address is not aligned to the access width |

## Verification
The sweep crosses the low three base bits with all four combinations of indexing style and writeback request. It also covers both add and subtract, every size code, and both offset sources. This separates the unchanged-base, updated-base and original-base selections, and it exposes every alignment residue for each width.

A second sweep runs the shift amount through 0 to 31 on a register offset with bits set near both ends. This catches dropped or misplaced shifter stages and wrong treatment of overflow bits.

Directed cases wrap the address through zero in both directions, and reproduce the decrement, the post-increment and the index-scaling examples.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;

    localparam int unsigned AGU_XLEN  = 32;
    localparam int unsigned AGU_IMM_W = 12;
    localparam int unsigned AGU_SH_W  = $clog2(AGU_XLEN);

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        IX_PRE  = 1'b0,
        IX_POST = 1'b1
    } idx_mode_e;

    typedef enum logic {
        OS_IMM = 1'b0,
        OS_REG = 1'b1
    } ofs_src_e;

    typedef struct packed {
        logic [AGU_XLEN-1:0] addr;
        logic [AGU_XLEN-1:0] new_base;
        logic                wb_en;
        logic                misalign;
    } agu_res_t;

    // Low address bits that must be zero for an access of the given width.
    function automatic logic [1:0] align_mask(acc_size_e sz);
        logic [1:0] m;
        unique case (sz)
            ACC_BYTE: m = 2'b00;
            ACC_HALF: m = 2'b01;
            default:  m = 2'b11;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/agu_offset.sv
`timescale 1ns/1ps
module agu_offset
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W = AGU_XLEN,
    parameter int unsigned IMM_W  = AGU_IMM_W,
    parameter int unsigned SH_W   = AGU_SH_W
) (
    input  ofs_src_e            src,
    input  logic [IMM_W-1:0]    imm,
    input  logic [ADDR_W-1:0]   rofs,
    input  logic [SH_W-1:0]     shamt,
    output logic [ADDR_W-1:0]   ofs
);
    localparam int unsigned PAD_W = ADDR_W - IMM_W;

    // Logarithmic left shifter: stage k moves the value by 2**k positions.
    logic [ADDR_W-1:0] stg [SH_W+1];
    assign stg[0] = rofs;

    for (genvar k = 0; k < SH_W; k++) begin : g_shift
        assign stg[k+1] = shamt[k] ? (stg[k] << (2**k)) : stg[k];
    end

    logic [ADDR_W-1:0] imm_ext;
    assign imm_ext = {{PAD_W{1'b0}}, imm};

    always_comb begin
        unique case (src)
            OS_REG:  ofs = stg[SH_W];
            default: ofs = imm_ext;
        endcase
    end
endmodule

// File: rtl/agu_sum.sv
`timescale 1ns/1ps
module agu_sum #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ofs,
    input  logic              sub,
    output logic [ADDR_W-1:0] sum
);
    // One carry chain for both directions: subtraction uses the inverted offset plus a carry-in.
    logic [ADDR_W-1:0] ofs_x;
    logic [ADDR_W-1:0] cin;

    assign ofs_x = ofs ^ {ADDR_W{sub}};
    assign cin   = {{(ADDR_W-1){1'b0}}, sub};
    assign sum   = base + ofs_x + cin;
endmodule

// File: rtl/agu_align.sv
`timescale 1ns/1ps
module agu_align
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W = AGU_XLEN
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output logic              misalign
);
    logic [1:0] mask;
    assign mask     = align_mask(size);
    assign misalign = |(addr[1:0] & mask);
endmodule

// File: rtl/agu_stage.sv
`timescale 1ns/1ps
module agu_stage
    import agu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  agu_res_t d,
    output agu_res_t q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/ls_agu_top.sv
`timescale 1ns/1ps
module ls_agu_top
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W  = AGU_XLEN,
    parameter int unsigned IMM_W   = AGU_IMM_W,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic                      ofs_sel_i,
    input  logic [IMM_W-1:0]          imm_i,
    input  logic [ADDR_W-1:0]         rofs_i,
    input  logic [$clog2(ADDR_W)-1:0] shamt_i,
    input  logic                      sub_i,
    input  logic                      post_i,
    input  logic                      wb_i,
    input  logic [1:0]                size_i,
    output logic [ADDR_W-1:0]         addr_o,
    output logic [ADDR_W-1:0]         new_base_o,
    output logic                      wb_en_o,
    output logic                      misalign_o
);
    localparam int unsigned SH_W = $clog2(ADDR_W);

    ofs_src_e  src;
    idx_mode_e mode;
    acc_size_e asz;

    assign src  = ofs_src_e'(ofs_sel_i);
    assign mode = idx_mode_e'(post_i);
    assign asz  = acc_size_e'(size_i);

    logic [ADDR_W-1:0] ofs;
    logic [ADDR_W-1:0] adj;

    agu_offset #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) i_ofs (
        .src   (src),
        .imm   (imm_i),
        .rofs  (rofs_i),
        .shamt (shamt_i),
        .ofs   (ofs)
    );

    agu_sum #(.ADDR_W(ADDR_W)) i_sum (
        .base (base_i),
        .ofs  (ofs),
        .sub  (sub_i),
        .sum  (adj)
    );

    agu_res_t nxt;
    agu_res_t cur;
    logic     mis;

    always_comb begin
        nxt = '0;
        unique case (mode)
            IX_POST: begin
                nxt.addr     = base_i;
                nxt.new_base = adj;
                nxt.wb_en    = 1'b1;
            end
            default: begin
                nxt.addr     = adj;
                nxt.new_base = wb_i ? adj : base_i;
                nxt.wb_en    = wb_i;
            end
        endcase
        nxt.misalign = mis;
    end

    agu_align #(.ADDR_W(ADDR_W)) i_align (
        .addr     (nxt.addr),
        .size     (asz),
        .misalign (mis)
    );

    agu_stage #(.REG_OUT(REG_OUT)) i_stage (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign addr_o     = cur.addr;
    assign new_base_o = cur.new_base;
    assign wb_en_o    = cur.wb_en;
    assign misalign_o = cur.misalign;
endmodule

// File: rtl/agu_checker.sv
`timescale 1ns/1ps
module agu_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] base_i,
    input logic              post_i,
    input logic              wb_i,
    input logic [1:0]        size_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [ADDR_W-1:0] new_base_o,
    input logic              wb_en_o,
    input logic              misalign_o
);
    if (REG_OUT) begin : g_seq
        p_pre_keep_r3: assert property (@(posedge clk) disable iff (rst)
            (!post_i && !wb_i) |=> (new_base_o == $past(base_i) && !wb_en_o));
        p_pre_wb_r4: assert property (@(posedge clk) disable iff (rst)
            (!post_i && wb_i) |=> (wb_en_o && addr_o == new_base_o));
        p_post_r5: assert property (@(posedge clk) disable iff (rst)
            post_i |=> (wb_en_o && addr_o == $past(base_i)));
        p_byte_r6: assert property (@(posedge clk) disable iff (rst)
            (size_i == 2'b00) |=> !misalign_o);
        p_half_r6: assert property (@(posedge clk) disable iff (rst)
            (size_i == 2'b01) |=> (misalign_o == addr_o[0]));
        p_word_r6: assert property (@(posedge clk) disable iff (rst)
            size_i[1] |=> (misalign_o == (addr_o[1:0] != 2'b00)));
        p_reset_r7: assert property (@(posedge clk)
            rst |=> (addr_o == '0 && new_base_o == '0 && !wb_en_o && !misalign_o));
    end else begin : g_comb
        p_pre_keep_r3: assert property (@(posedge clk) disable iff (rst)
            (!post_i && !wb_i) |-> (new_base_o == base_i && !wb_en_o));
        p_pre_wb_r4: assert property (@(posedge clk) disable iff (rst)
            (!post_i && wb_i) |-> (wb_en_o && addr_o == new_base_o));
        p_post_r5: assert property (@(posedge clk) disable iff (rst)
            post_i |-> (wb_en_o && addr_o == base_i));
        p_byte_r6: assert property (@(posedge clk) disable iff (rst)
            (size_i == 2'b00) |-> !misalign_o);
        p_half_r6: assert property (@(posedge clk) disable iff (rst)
            (size_i == 2'b01) |-> (misalign_o == addr_o[0]));
        p_word_r6: assert property (@(posedge clk) disable iff (rst)
            size_i[1] |-> (misalign_o == (addr_o[1:0] != 2'b00)));
    end
endmodule

bind ls_agu_top agu_checker #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) i_agu_chk (
    .clk        (clk),
    .rst        (rst),
    .base_i     (base_i),
    .post_i     (post_i),
    .wb_i       (wb_i),
    .size_i     (size_i),
    .addr_o     (addr_o),
    .new_base_o (new_base_o),
    .wb_en_o    (wb_en_o),
    .misalign_o (misalign_o)
);

// File: tb/test_ls_agu_top.sv
`timescale 1ns/1ps
module test_ls_agu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_i = '0;
    logic        ofs_sel_i = 1'b0;
    logic [11:0] imm_i = '0;
    logic [31:0] rofs_i = '0;
    logic [4:0]  shamt_i = '0;
    logic        sub_i = 1'b0;
    logic        post_i = 1'b0;
    logic        wb_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic [31:0] addr_o;
    logic [31:0] new_base_o;
    logic        wb_en_o;
    logic        misalign_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ls_agu_top i_ls_agu_top (
        .clk(clk), .rst(rst), .base_i(base_i), .ofs_sel_i(ofs_sel_i),
        .imm_i(imm_i), .rofs_i(rofs_i), .shamt_i(shamt_i), .sub_i(sub_i),
        .post_i(post_i), .wb_i(wb_i), .size_i(size_i),
        .addr_o(addr_o), .new_base_o(new_base_o), .wb_en_o(wb_en_o),
        .misalign_o(misalign_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference arithmetic, derived from the requirements only.
    function automatic logic [31:0] ref_ofs(bit sel, logic [11:0] imm,
                                            logic [31:0] r, int sh);
        longint unsigned p;
        if (!sel) return {20'd0, imm};
        p = longint'(r) * (64'd1 << sh);
        return p[31:0];
    endfunction

    task automatic drive(input logic [31:0] b, input bit sel, input logic [11:0] imm,
                         input logic [31:0] r, input int sh, input bit sb,
                         input bit po, input bit w, input logic [1:0] sz);
        base_i = b; ofs_sel_i = sel; imm_i = imm; rofs_i = r;
        shamt_i = 5'(sh); sub_i = sb; post_i = po; wb_i = w; size_i = sz;
    endtask

    task automatic run(input logic [31:0] b, input bit sel, input logic [11:0] imm,
                       input logic [31:0] r, input int sh, input bit sb,
                       input bit po, input bit w, input logic [1:0] sz);
        logic [31:0] o, adj, ea, nb;
        longint unsigned t;
        bit en, mis;
        string tg;
        o = ref_ofs(sel, imm, r, sh);
        t = sb ? (longint'(b) + 64'h1_0000_0000 - longint'(o)) : (longint'(b) + longint'(o));
        adj = t[31:0];
        if (po) begin ea = b; nb = adj; en = 1'b1; tg = "R5"; end
        else if (w) begin ea = adj; nb = adj; en = 1'b1; tg = "R4"; end
        else begin ea = adj; nb = b; en = 1'b0; tg = "R3"; end
        if (sz == 2'b00) mis = 1'b0;
        else if (sz == 2'b01) mis = (ea % 2) != 0;
        else mis = (ea % 4) != 0;
        @(negedge clk);
        drive(b, sel, imm, r, sh, sb, po, w, sz);
        @(posedge clk);
        @(negedge clk);
        chk(tg, "addr", addr_o, ea);
        chk(tg, "new_base", new_base_o, nb);
        chk(tg, "wb_en", {31'd0, wb_en_o}, {31'd0, en});
        chk("R6", "misalign", {31'd0, misalign_o}, {31'd0, mis});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R7: reset clears every output even with live operands
        drive(32'h1234_5677, 1'b0, 12'h0FF, 32'h1, 1, 1'b0, 1'b1, 1'b1, 2'b10);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7", "reset addr", addr_o, 32'h0);
        chk("R7", "reset new_base", new_base_o, 32'h0);
        chk("R7", "reset flags", {30'd0, wb_en_o, misalign_o}, 32'h0);
        rst = 1'b0;

        // R7: outputs follow only at the next rising edge
        run(32'h0000_0100, 1'b0, 12'h004, 32'h0, 0, 1'b0, 1'b0, 1'b0, 2'b10);
        @(negedge clk);
        drive(32'h0000_0800, 1'b0, 12'h010, 32'h0, 0, 1'b0, 1'b0, 1'b0, 2'b10);
        #1;
        chk("R7", "hold before edge", addr_o, 32'h0000_0104);
        @(posedge clk);
        @(negedge clk);
        chk("R7", "update after edge", addr_o, 32'h0000_0810);

        // R2: decrement example, pre-indexed with writeback
        run(32'h0000_0200, 1'b0, 12'h004, 32'h0, 0, 1'b1, 1'b0, 1'b1, 2'b10);
        chk("R2", "decrement", new_base_o, 32'h0000_01FC);
        // R5: post-increment example
        run(32'h0000_0200, 1'b0, 12'h00C, 32'h0, 0, 1'b0, 1'b1, 1'b0, 2'b10);
        chk("R5", "post addr", addr_o, 32'h0000_0200);
        chk("R5", "post base", new_base_o, 32'h0000_020C);
        // R1: index 3 scaled by shift 2
        run(32'h0000_0100, 1'b1, 12'hFFF, 32'h3, 2, 1'b0, 1'b0, 1'b0, 2'b10);
        chk("R1", "scaled index", addr_o, 32'h0000_010C);
        // R2: wrap upward and downward through zero
        run(32'hFFFF_FFF8, 1'b0, 12'h010, 32'h0, 0, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R2", "wrap up", addr_o, 32'h0000_0008);
        run(32'h0000_0004, 1'b0, 12'h008, 32'h0, 0, 1'b1, 1'b0, 1'b0, 2'b00);
        chk("R2", "wrap down", addr_o, 32'hFFFF_FFFC);
        // R1: immediate of full width is zero-extended
        run(32'h0000_0000, 1'b0, 12'hFFF, 32'hFFFF_FFFF, 0, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R1", "imm zero-extend", addr_o, 32'h0000_0FFF);

        // R8: every shift amount on a pattern with both end bits set
        for (int s = 0; s < 32; s++) begin
            run(32'h8000_0000, 1'b1, 12'h000, 32'hF000_0003, s, 1'b0, 1'b0, 1'b1, 2'b00);
        end
        run(32'h0000_0000, 1'b1, 12'h000, 32'h0000_0001, 31, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R8", "shift 31", addr_o, 32'h8000_0000);

        // R3 R4 R5 R6 R1 R2: cross sweep of low base bits and every mode code
        for (int b = 0; b < 8; b++)
            for (int m = 0; m < 4; m++)
                for (int sb = 0; sb < 2; sb++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int sl = 0; sl < 2; sl++)
                            run(32'h0000_1000 + 32'(b), sl[0], 12'(5 + m + 2*sz),
                                32'(3 + b), m + sb, sb[0], m[1], m[0], sz[1:0]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule